// File: doc/BRIEF.md
# Reset-Gated Chip-Enable Path

This block sits between a processor's active-low memory chip-enable and a battery-backed static memory. In normal operation the chip-enable passes straight through, with no clock delay, so memory timing is untouched. When the supply supervisor raises its reset flag, the block closes the path and drives its output inactive (high), so writes issued while the supply collapses cannot corrupt the memory.

A memory access already under way when reset arrives is not cut short at once. If the chip-enable is low in the first reset cycle, the output stays low until the input rises or a hold window runs out, whichever comes first. The window is a clock count computed from the clock frequency and a hold time in nanoseconds (15 µs by default). Once the output has returned high during reset, it stays high until reset clears.

Top module: `ce_reset_gate`

## Requirements
- R1: While `sys_rst` is 0, `ce_out_n` equals `ce_in_n` in the same cycle, for every input pattern.
- R2: While `sys_rst` is 1 and the hold window is not open, `ce_out_n` is 1 whatever `ce_in_n` does.
- R3: `ce_out_n` is 0 only in a cycle where `ce_in_n` is 0.
- R4: If `ce_in_n` is 0 in the first cycle that `sys_rst` is 1, after at least one normal cycle, `ce_out_n` stays 0 in that cycle.
- R5: An open hold window closes at the first clock edge where `ce_in_n` is 1. From then on `ce_out_n` stays 1 until `sys_rst` returns to 0, even if `ce_in_n` goes low again.
- R6: An open hold window lasts at most HOLD_CYC = CLK_HZ/1000 * HOLD_NS / 1e6 cycles (1500 at 100 MHz and 15000 ns). With `ce_in_n` held at 0, `ce_out_n` is 0 for exactly HOLD_CYC cycles of reset and then 1.
- R7: In the cycle `sys_rst` returns to 0 with `ce_in_n` already 0, `ce_out_n` is 0 in that same cycle.
- R8: While `rst_n` is 0 the hold window is closed, so `ce_out_n` is 1 whenever `sys_rst` is 1. A window can only open after a normal cycle following `rst_n` release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the hold-window logic |
| rst_n | input | 1 | Asynchronous active-low register reset |
| sys_rst | input | 1 | Supply supervisor reset flag, active high |
| ce_in_n | input | 1 | Chip-enable from the processor, active low |
| ce_out_n | output | 1 | Gated chip-enable to the memory, active low |

## Verification
The only state is the window-open flag and its cycle counter. A flag stuck open shows up as `ce_out_n` following the input during reset; this appears the first cycle the input falls after an access has ended. A flag stuck closed shows up as an access being cut off in the very first reset cycle. A counter that is off by one moves the rising edge of `ce_out_n` by one cycle at the end of a full-length hold. That is only visible when the input stays low for the whole window, so the bench forces that case as well as random ones.

// File: rtl/ceg_pkg.sv
package ceg_pkg;

   // Clock count covering a hold time given in nanoseconds.
   function automatic int unsigned hold_cycles(longint unsigned clk_hz,
                                               longint unsigned hold_ns);
      longint unsigned khz;
      khz = clk_hz / 1000;
      return int'((khz * hold_ns) / 1_000_000);
   endfunction

   function automatic int unsigned cnt_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ceg_hold_timer.sv
module ceg_hold_timer #(
   parameter int unsigned HOLD_CYC = 1500,
   parameter int unsigned CW       = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_rst,
   input  logic ce_in_n,
   output logic win_open
);
   generate
      if (HOLD_CYC == 0) begin : g_no_hold
         // Zero window: reset cuts the path at once.
         assign win_open = 1'b0;
      end else begin : g_hold
         localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);
         logic          open_q;
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               open_q <= 1'b0;
               cnt_q  <= '0;
            end else if (!sys_rst) begin
               open_q <= 1'b1;
               cnt_q  <= '0;
            end else if (open_q) begin
               if (ce_in_n || cnt_q == LAST) open_q <= 1'b0;
               else                          cnt_q  <= cnt_q + 1'b1;
            end
         end

         assign win_open = open_q;
      end
   endgenerate
endmodule

// File: rtl/ceg_gate.sv
module ceg_gate (
   input  logic ce_in_n,
   input  logic sys_rst,
   input  logic win_open,
   output logic ce_out_n
);
   logic blocked;
   always_comb begin
      blocked  = sys_rst & ~win_open;
      ce_out_n = ce_in_n | blocked;
   end
endmodule

// File: rtl/ce_reset_gate.sv
module ce_reset_gate #(
   parameter longint unsigned CLK_HZ  = 100_000_000,
   parameter longint unsigned HOLD_NS = 15_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_rst,
   input  logic ce_in_n,
   output logic ce_out_n
);
   import ceg_pkg::*;

   localparam int unsigned HOLD_CYC = hold_cycles(CLK_HZ, HOLD_NS);
   localparam int unsigned CW       = cnt_width(HOLD_CYC);

   initial begin
      assert (CLK_HZ >= 1000) else $error("CLK_HZ must be at least 1 kHz");
      assert (HOLD_CYC < 32'h0100_0000) else $error("hold window too long");
   end

   logic win_open;

   ceg_hold_timer #(.HOLD_CYC(HOLD_CYC), .CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sys_rst  (sys_rst),
      .ce_in_n  (ce_in_n),
      .win_open (win_open)
   );

   ceg_gate u_gate (
      .ce_in_n  (ce_in_n),
      .sys_rst  (sys_rst),
      .win_open (win_open),
      .ce_out_n (ce_out_n)
   );
endmodule

// File: rtl/ce_reset_gate_chk.sv
module ce_reset_gate_chk #(
   parameter int unsigned HOLD_CYC = 1500,
   parameter int unsigned CW       = 11
) (
   input logic clk,
   input logic rst_n,
   input logic sys_rst,
   input logic ce_in_n,
   input logic ce_out_n
);
   logic [CW:0] low_run_q;
   logic        primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run_q <= '0;
         primed_q  <= 1'b0;
      end else begin
         low_run_q <= (sys_rst && !ce_out_n) ? low_run_q + 1'b1 : '0;
         primed_q  <= !sys_rst;
      end
   end

   // R1
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_rst |-> ce_out_n == ce_in_n);

   // R3
   low_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_in_n |-> ce_out_n);

   // R5
   stays_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_rst && $past(sys_rst) && $past(ce_out_n)) |-> ce_out_n);

   // R6
   hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_rst && !ce_out_n) |-> low_run_q < (CW+1)'(HOLD_CYC));

   generate
      if (HOLD_CYC > 0) begin : g_onset
         // R4
         onset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (primed_q && sys_rst && !ce_in_n) |-> !ce_out_n);
      end
   endgenerate
endmodule

bind ce_reset_gate ce_reset_gate_chk #(.HOLD_CYC(HOLD_CYC), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sys_rst  (sys_rst),
   .ce_in_n  (ce_in_n),
   .ce_out_n (ce_out_n)
);

// File: tb/tb_ce_reset_gate.sv
module tb_ce_reset_gate;
   localparam longint unsigned CLK_HZ  = 4_000_000;
   localparam longint unsigned HOLD_NS = 15_000;
   localparam int HOLD = 60; // 4000 kHz * 15000 ns / 1e6

   logic clk = 1'b0;
   logic rst_n, sys_rst, ce_in_n;
   logic ce_out_n;
   int checks = 0, failures = 0;
   bit done = 0;

   // bench model state
   bit m_open = 0;
   int m_cnt = 0;
   bit prev_rst = 0;

   always #5 clk = ~clk;

   ce_reset_gate #(.CLK_HZ(CLK_HZ), .HOLD_NS(HOLD_NS)) dut (
      .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
      .ce_in_n(ce_in_n), .ce_out_n(ce_out_n));

   function automatic bit expect_out(bit ce, bit rst, bit open);
      if (!rst) return ce;
      return ce | ~open;
   endfunction

   function automatic string pick_tag(bit ce, bit rst, bit prst, bit open, bit rn);
      if (!rn)          return "R8";
      if (!rst && prst) return "R7";
      if (!rst)         return "R1";
      if (ce)           return "R3";
      if (open && !prst) return "R4";
      if (open)         return "R6";
      return "R5/R2";
   endfunction

   task automatic step(bit rn, bit rst, bit ce);
      bit exp;
      string tag;
      @(negedge clk);
      rst_n = rn; sys_rst = rst; ce_in_n = ce;
      if (!rn) begin m_open = 0; m_cnt = 0; end
      #4;
      exp = expect_out(ce, rst, m_open);
      tag = pick_tag(ce, rst, prev_rst, m_open, rn);
      checks++;
      if (ce_out_n !== exp) begin
         failures++;
         $display("FAIL %s: ce_out_n=%b expected=%b (rst=%b ce=%b)",
                  tag, ce_out_n, exp, rst, ce);
      end
      @(posedge clk);
      if (!rn) begin m_open = 0; m_cnt = 0; end
      else if (!rst) begin m_open = 1; m_cnt = 0; end
      else if (m_open) begin
         if (ce || m_cnt == HOLD - 1) m_open = 0;
         else m_cnt++;
      end
      prev_rst = rst;
   endtask

   initial begin
      bit r, c;
      void'($urandom(32'd4242));
      // R8: register reset, supervisor reset high, input low
      step(0, 1, 0);
      step(0, 1, 0);
      step(1, 1, 0); // window stays shut after release (R8)
      step(1, 1, 1);
      // R1: normal pass-through
      step(1, 0, 1); step(1, 0, 0); step(1, 0, 1); step(1, 0, 0);
      // R4 + R6: full-length hold with input held low
      for (int i = 0; i < HOLD + 5; i++) step(1, 1, 0);
      // R7: release with input low
      step(1, 0, 0); step(1, 0, 0);
      // R5: input rises mid-hold, then falls again
      for (int i = 0; i < 10; i++) step(1, 1, 0);
      step(1, 1, 1);
      for (int i = 0; i < 8; i++) step(1, 1, 0);
      step(1, 0, 1);
      // R2: input high at reset onset, then low during reset
      step(1, 1, 1);
      for (int i = 0; i < 5; i++) step(1, 1, 0);
      step(1, 0, 0);
      // constrained random mix
      r = 0; c = 1;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 29) == 0) r = ~r;
         if ($urandom_range(0, (r ? 39 : 3)) == 0) c = ~c;
         step(($urandom_range(0, 999) != 0), r, c);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(2_000_000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule